// File: doc/BRIEF.md
# Dual-Port Wake-Up Forwarding Controller

This block is the digital decision logic for wake-up handling in a two-port Ethernet PHY pair that shares one bidirectional wake pin. Each port reports a remote wake detection strobe and its current link state. From these, and from four enable bits held per port, the block decides in each cycle whether a port's PHY should wake and whether the event should travel further. An event can travel onto a port's own cable, across to the other port, or out on the shared pin.

Forwarding onto a cable takes one of two forms. On a link that is down, the block requests a wake pulse of fixed length. On a link that is up, it requests wake-request code groups for a fixed number of cycles instead. When the block drives the shared pin, it holds the pin for a programmable number of cycles and then lets go. A small write-only register port sets the per-port enables and the pin hold time. A write to a port's enable register is also a wake source for that port.

Top module: `wake_fwd_ctrl`

## Requirements
- R1: A remote wake strobe on port p wakes that port (`phy_wake[p]` high for one cycle, one clock after the strobe) only if enable bit 0 of port p is set.
- R2: With enable bit 2 of port p set, port p wakes one clock after a local event. A local event is a rising edge on the wake pin, an event passed over from the other port, or a register write to port p.
- R3: An event that starts at port p is passed to the other port and starts a pin drive only if enable bit 3 of port p is set. Such an event is either a remote strobe accepted under bit 0 or a register write to port p.
- R4: With enable bit 1 of port p set, a wake-pin rising edge or an event passed over from the other port starts a forwarding sequence on port p's cable. The sequence starts one clock later.
- R5: If the port's link was down at the decision, the sequence raises `pulse_req[p]` for exactly PULSE_CYC cycles. If the link was up, it raises `code_req[p]` for exactly CODE_CYC cycles. The two are never high together.
- R6: While a port's sequence is running, new forwarding requests for that port are dropped. The sequence length does not change.
- R7: The wake pin acts only on a rising edge. A pin held high produces a single event.
- R8: Writing N to address 2 sets the hold time. A pin drive then lasts N+1 cycles, and requests that arrive while the pin is driven are dropped.
- R9: Edges on the wake pin while the block drives it are ignored, so the block's own drive never triggers a wake or a forward.
- R10: A write sets port 0's enables at address 0 and port 1's at address 1, using `reg_wdata[3:0]`. The written port is handled as having a local event in the following cycle, using the newly written enables.
- R11: After reset all enables and the hold time are zero, no sequence runs, the pin is released and every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| remote_wake | input | 2 | One-cycle remote wake detection strobe per port |
| link_up | input | 2 | Link active flag per port |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0, 1 enables; 2 hold time) |
| reg_wdata | input | HOLD_W | Register write data |
| wpin_in | input | 1 | Sampled level of the shared wake pin |
| wpin_drive | output | 1 | Drive the shared wake pin high |
| phy_wake | output | 2 | One-cycle wake command per PHY |
| pulse_req | output | 2 | Wake pulse request per port |
| code_req | output | 2 | Wake-request code group request per port |

## Verification
A wrong enable bit or a wrong routing path shows at the ports one clock after the triggering strobe, edge or write. It appears as a missing or extra `phy_wake` strobe, or as a sequence that starts on the wrong port. A sequence counter that is loaded or decremented wrongly shows as a request that is too long or too short, or of the wrong kind. A fault in the busy gating shows as a sequence that restarts. These become visible when the request falls, at most CODE_CYC cycles after the sequence starts. A bad pin-edge or hold state shows up within the hold window: the drive length is wrong, or the block wakes itself on the release edge.

// File: rtl/wake_fwd_ctrl.sv
module wake_fwd_ctrl #(
  parameter int PULSE_CYC = 16,
  parameter int CODE_CYC  = 40,
  parameter int HOLD_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        remote_wake,
  input  logic [1:0]        link_up,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [HOLD_W-1:0] reg_wdata,
  input  logic              wpin_in,
  output logic              wpin_drive,
  output logic [1:0]        phy_wake,
  output logic [1:0]        pulse_req,
  output logic [1:0]        code_req
);
  localparam int LEN_MAX = (PULSE_CYC > CODE_CYC) ? PULSE_CYC : CODE_CYC;
  localparam int CW = $clog2(LEN_MAX + 1);
  localparam logic [CW-1:0] PULSE_LEN = CW'(PULSE_CYC);
  localparam logic [CW-1:0] CODE_LEN  = CW'(CODE_CYC);
  localparam int ACT_REM = 0, FWD_LINE = 1, WAKE_LOC = 2, FWD_OUT = 3;

  logic [1:0][3:0]    en;
  logic [HOLD_W-1:0]  hold_cfg, hcnt;
  logic               pin_q;
  logic [1:0]         mgmt_ev;
  logic [1:0][CW-1:0] cnt;
  logic [1:0]         is_code;
  logic               pin_rise;
  logic [1:0]         rem_ok, xfer, wake_now, line_req, busy;

  assign pin_rise = wpin_in & ~pin_q & ~wpin_drive;

  for (genvar p = 0; p < 2; p++) begin : g_port
    localparam int Q = 1 - p;
    assign rem_ok[p]    = remote_wake[p] & en[p][ACT_REM];
    assign xfer[p]      = (rem_ok[p] | mgmt_ev[p]) & en[p][FWD_OUT];
    assign wake_now[p]  = rem_ok[p] | (en[p][WAKE_LOC] & (pin_rise | xfer[Q] | mgmt_ev[p]));
    assign line_req[p]  = en[p][FWD_LINE] & (pin_rise | xfer[Q]);
    assign busy[p]      = cnt[p] != '0;
    assign pulse_req[p] = busy[p] & ~is_code[p];
    assign code_req[p]  = busy[p] & is_code[p];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en       <= '0;
      hold_cfg <= '0;
      mgmt_ev  <= '0;
      pin_q    <= 1'b0;
      phy_wake <= '0;
    end else begin
      pin_q    <= wpin_in;
      phy_wake <= wake_now;
      mgmt_ev  <= {reg_wr && reg_addr == 2'd1, reg_wr && reg_addr == 2'd0};
      if (reg_wr) begin
        case (reg_addr)
          2'd0:    en[0]    <= reg_wdata[3:0];
          2'd1:    en[1]    <= reg_wdata[3:0];
          2'd2:    hold_cfg <= reg_wdata;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      is_code <= '0;
    end else begin
      for (int p = 0; p < 2; p++) begin
        if (busy[p]) begin
          cnt[p] <= cnt[p] - 1'b1;
        end else if (line_req[p]) begin
          cnt[p]     <= link_up[p] ? CODE_LEN : PULSE_LEN;
          is_code[p] <= link_up[p];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wpin_drive <= 1'b0;
      hcnt       <= '0;
    end else if (wpin_drive) begin
      if (hcnt == '0) wpin_drive <= 1'b0;
      else            hcnt       <= hcnt - 1'b1;
    end else if (|xfer) begin
      wpin_drive <= 1'b1;
      hcnt       <= hold_cfg;
    end
  end
endmodule

// File: rtl/wake_fwd_ctrl_chk.sv
module wake_fwd_ctrl_chk #(
  parameter int PULSE_CYC = 16,
  parameter int CODE_CYC  = 40
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] remote_wake,
  input logic [1:0] link_up,
  input logic       reg_wr,
  input logic       wpin_in,
  input logic       wpin_drive,
  input logic [1:0] phy_wake,
  input logic [1:0] pulse_req,
  input logic [1:0] code_req
);
  int plen, clen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      plen <= 0;
      clen <= 0;
    end else begin
      plen <= pulse_req[1] ? plen + 1 : 0;
      clen <= code_req[1] ? clen + 1 : 0;
    end
  end

  p_wake_has_source_r1: assert property (@(posedge clk) disable iff (!rst_n)
    phy_wake[0] |-> ($past(remote_wake[0]) || $past(remote_wake[1]) || $past(wpin_in) || $past(reg_wr, 2)));

  p_drive_has_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wpin_drive) |-> ($past(remote_wake[0]) || $past(remote_wake[1]) || $past(reg_wr, 2)));

  p_pulse_on_down_link_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_req[1]) |-> !$past(link_up[1]));

  p_code_on_up_link_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(code_req[1]) |-> $past(link_up[1]));

  p_pulse_length_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pulse_req[1]) |-> plen == PULSE_CYC);

  p_code_length_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(code_req[1]) |-> clen == CODE_CYC);

  p_no_kind_switch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(code_req[0]) |-> !$past(pulse_req[0]));
endmodule

bind wake_fwd_ctrl wake_fwd_ctrl_chk #(.PULSE_CYC(PULSE_CYC), .CODE_CYC(CODE_CYC)) i_chk (
  .clk(clk), .rst_n(rst_n), .remote_wake(remote_wake), .link_up(link_up), .reg_wr(reg_wr),
  .wpin_in(wpin_in), .wpin_drive(wpin_drive), .phy_wake(phy_wake),
  .pulse_req(pulse_req), .code_req(code_req)
);

// File: tb/test_wake_fwd_ctrl.sv
`timescale 1ns/1ps
module test_wake_fwd_ctrl;
  localparam int P = 6, C = 9, HW = 8;

  logic clk = 0, rst_n = 0;
  logic [1:0] remote_wake = 0, link_up = 0;
  logic reg_wr = 0;
  logic [1:0] reg_addr = 0;
  logic [HW-1:0] reg_wdata = 0;
  logic ext_pin = 0;
  logic wpin_in, wpin_drive;
  logic [1:0] phy_wake, pulse_req, code_req;
  int n_chk = 0, n_fail = 0;

  assign wpin_in = ext_pin | wpin_drive;
  always #4 clk = ~clk;

  wake_fwd_ctrl #(.PULSE_CYC(P), .CODE_CYC(C), .HOLD_W(HW)) i_wake_fwd_ctrl (
    .clk(clk), .rst_n(rst_n), .remote_wake(remote_wake), .link_up(link_up),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .wpin_in(wpin_in),
    .wpin_drive(wpin_drive), .phy_wake(phy_wake), .pulse_req(pulse_req), .code_req(code_req));

  // reference model built from the requirements
  logic [3:0] m_en [2];
  int m_hold, m_hcnt, m_cnt [2];
  logic m_code [2], m_wake [2], m_mev [2], m_pinq, m_drive;
  logic t_rise;
  logic t_rem [2], t_xf [2], t_wk [2], t_lr [2];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < 2; p++) begin
        m_en[p] = 0; m_cnt[p] = 0; m_code[p] = 0; m_wake[p] = 0; m_mev[p] = 0;
      end
      m_hold = 0; m_hcnt = 0; m_pinq = 0; m_drive = 0;
    end else begin
      t_rise = (ext_pin | m_drive) & !m_pinq & !m_drive;
      for (int p = 0; p < 2; p++) begin
        t_rem[p] = remote_wake[p] & m_en[p][0];
        t_xf[p]  = (t_rem[p] | m_mev[p]) & m_en[p][3];
      end
      for (int p = 0; p < 2; p++) begin
        t_wk[p] = t_rem[p] | (m_en[p][2] & (t_rise | t_xf[1-p] | m_mev[p]));
        t_lr[p] = m_en[p][1] & (t_rise | t_xf[1-p]);
      end
      m_pinq = ext_pin | m_drive;
      for (int p = 0; p < 2; p++) begin
        m_wake[p] = t_wk[p];
        if (m_cnt[p] != 0) m_cnt[p]--;
        else if (t_lr[p]) begin m_cnt[p] = link_up[p] ? C : P; m_code[p] = link_up[p]; end
      end
      if (m_drive) begin
        if (m_hcnt == 0) m_drive = 0; else m_hcnt--;
      end else if (t_xf[0] | t_xf[1]) begin
        m_drive = 1; m_hcnt = m_hold;
      end
      for (int p = 0; p < 2; p++) m_mev[p] = reg_wr && reg_addr == 2'(p);
      if (reg_wr) begin
        if (reg_addr == 0) m_en[0] = reg_wdata[3:0];
        if (reg_addr == 1) m_en[1] = reg_wdata[3:0];
        if (reg_addr == 2) m_hold = int'(reg_wdata);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_pulse(int p);
    return (m_cnt[p] != 0 && !m_code[p]) ? 1 : 0;
  endfunction
  function automatic int exp_code(int p);
    return (m_cnt[p] != 0 && m_code[p]) ? 1 : 0;
  endfunction

  task automatic cmp();
    for (int p = 0; p < 2; p++) begin
      chk(phy_wake[p] == m_wake[p], "R1 R2 phy_wake", int'(phy_wake[p]), int'(m_wake[p]));
      chk(pulse_req[p] == exp_pulse(p), "R5 pulse_req", int'(pulse_req[p]), exp_pulse(p));
      chk(code_req[p] == exp_code(p), "R5 code_req", int'(code_req[p]), exp_code(p));
    end
    chk(wpin_drive == m_drive, "R8 wpin_drive", int'(wpin_drive), int'(m_drive));
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    cmp();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr(input logic [1:0] a, input logic [HW-1:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 0;
  endtask

  int np, nc, nd, nw;

  task automatic count_run(int port, int n);
    np = int'(pulse_req[port]); nc = int'(code_req[port]); nd = int'(wpin_drive); nw = 0;
    for (int i = 0; i < n; i++) begin
      tick();
      np += int'(pulse_req[port]); nc += int'(code_req[port]);
      nd += int'(wpin_drive); nw += int'(phy_wake[port]);
    end
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h00c0ffee));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(phy_wake == 0 && pulse_req == 0 && code_req == 0 && wpin_drive == 0, "R11 reset outputs",
        int'({phy_wake, pulse_req, code_req, wpin_drive}), 0);

    remote_wake = 2'b11; tick(); remote_wake = 0;
    chk(phy_wake == 0, "R11 enables clear after reset", int'(phy_wake), 0);

    wr(0, 8'h01); idle(2);
    remote_wake = 2'b01; tick(); remote_wake = 0;
    chk(phy_wake == 2'b01, "R1 remote wake with enable", int'(phy_wake), 1);
    remote_wake = 2'b10; tick(); remote_wake = 0;
    chk(phy_wake == 2'b00, "R1 remote wake without enable", int'(phy_wake), 0);

    wr(2, 8'd3); wr(1, 8'h06); wr(0, 8'h09); idle(20);
    link_up = 2'b00;
    remote_wake = 2'b01; tick(); remote_wake = 0;
    chk(phy_wake == 2'b11, "R2 forwarded event wakes port 1", int'(phy_wake), 3);
    chk(pulse_req[1] == 1, "R4 forwarding sequence on port 1", int'(pulse_req[1]), 1);
    chk(wpin_drive == 1, "R3 forward out drives pin", int'(wpin_drive), 1);
    count_run(1, 20);
    chk(np == P, "R5 pulse length on down link", np, P);
    chk(nd == 4, "R8 hold 3 gives 4 drive cycles", nd, 4);
    chk(nw == 0, "R9 own drive does not retrigger", nw, 0);

    link_up = 2'b10;
    remote_wake = 2'b01; tick(); remote_wake = 0;
    count_run(1, 20);
    chk(nc == C && np == 0, "R5 code length on up link", nc, C);

    link_up = 2'b00;
    remote_wake = 2'b01; tick(); remote_wake = 0;
    tick(); tick();
    remote_wake = 2'b01; tick(); remote_wake = 0;
    chk(pulse_req[1] == 1, "R6 sequence still running", int'(pulse_req[1]), 1);
    count_run(1, 20);
    chk(np + 3 == P, "R6 busy request dropped", np + 3, P);

    wr(0, 8'h00); idle(20);
    ext_pin = 1; tick();
    chk(phy_wake[1] == 1 && pulse_req[1] == 1, "R7 pin rising edge", int'({phy_wake[1], pulse_req[1]}), 3);
    count_run(1, 25);
    chk(np == P && nw == 0, "R7 held pin gives one event", np, P);
    ext_pin = 0; idle(2);

    wr(1, 8'h04);
    chk(phy_wake[1] == 0, "R10 write not yet acted on", int'(phy_wake[1]), 0);
    tick();
    chk(phy_wake[1] == 1, "R10 write wakes addressed port", int'(phy_wake[1]), 1);
    wr(1, 8'h00); tick();
    chk(phy_wake[1] == 0, "R10 new enables used", int'(phy_wake[1]), 0);

    for (int i = 0; i < 4000; i++) begin
      remote_wake = 2'(($urandom % 12 == 0) ? $urandom : 0);
      if ($urandom % 40 == 0) link_up = 2'($urandom);
      if ($urandom % 25 == 0) ext_pin = ~ext_pin;
      if ($urandom % 30 == 0) begin
        reg_wr = 1; reg_addr = 2'($urandom % 4);
        reg_wdata = (reg_addr == 2) ? HW'($urandom % 8) : HW'($urandom);
      end else reg_wr = 0;
      tick();
    end
    reg_wr = 0; remote_wake = 0;
    idle(30);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule